// File: doc/BRIEF.md
# Local Timer Cell with Coherent Select Update

This block is one cell of a chain of timer cells. It keeps a 16-bit counter that advances on events taken from a single input line.

- In edge mode, the events are rising and/or falling transitions of the line.
- In level mode, the line acts as a gate with a chosen active level. While the gate is open, the counter advances on every clock or on each strobe from a shared prescaler.

A dedicated reset/overflow event input reloads the counter to zero.

The cell also drives a select-line output bit. Software can write this bit directly through an 8-bit control register. Software can also arm a one-shot coherent-update request, which flips the select output exactly at the next reset/overflow event. Hardware then drops the request. The request is set and cleared through a pair of bits: a readable flag and a write-only clear strobe. A write that carries both bits sets the flag. Bit 0 (the line mode) changes the meaning of bits 1 and 2.

The control register holds: bit 0 line mode (0 edge, 1 level); bit 1 falling-edge enable (edge) or active-low select (level); bit 2 rising-edge enable (edge) or prescaler enable (level); bit 3 full-speed clock select; bit 4 select output value; bit 5 request-clear strobe; bit 6 coherent-update request; bit 7 unused.

Top module: `ltc_cell`

## Requirements
- R1: After a synchronous active-low reset, the counter is 0, the select output is 0 and every control bit reads 0.
- R2: In edge mode (bit0=0), each rising transition of the line counts once when bit2=1, and each falling transition counts once when bit1=1. A disabled transition direction never counts. The line is registered twice, so the counter changes on the second rising clock edge after the line changes, and a held level adds no further counts.
- R3: In edge mode with the full-speed bit (bit3) at 1, the counter never advances on line activity.
- R4: In level mode (bit0=1), the line is active when high if bit1=0, and active when low if bit1=1. While the line is active, the counter advances on every clock when bit2=0, and only in cycles with the prescaler strobe high when bit2=1. While the line is inactive, the counter holds.
- R5: The reset/overflow event loads the counter with 0 on the next clock, overriding a count event in the same cycle. Counting otherwise wraps modulo 2^16.
- R6: Every register write loads bit4 into the select output, which appears on sel_out and reads back at bit4. Bits 0 to 3 also read back as written, and bit 7 reads 0.
- R7: For the request flag (bit6), a write with bit5=1 and bit6=1 sets it, a write with bit5=1 and bit6=0 clears it, and a write with bit5=0 leaves it unchanged.
- R8: Bit5 is write-only and always reads 0.
- R9: When the request flag is set and a reset/overflow event occurs, the select output flips once on that clock and the flag clears. Later events leave the select output alone.
- R10: A write that sets the request flag (bit5=1, bit6=1) in the same cycle as a reset/overflow event leaves the select output unflipped and the flag set. The flip happens at the next event instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_line | input | 1 | Count input line |
| presc_stb | input | 1 | Prescaler clock strobe, one cycle wide |
| ovf_evt | input | 1 | Reset/overflow event, reloads the counter |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| cnt | output | 16 | Counter value |
| sel_out | output | 1 | Select-line output |

## Verification
Two pairs of functions can fall in the same cycle: a count event against the reset/overflow reload, and a software write of the request flag against the event that consumes it. The first pair is provoked by holding the line active in full-speed level mode while pulsing the event. The counter must read 0 right after that edge and 1 one clock later. The second pair is provoked by issuing the set write on the very clock of the event. The bench then confirms that the select output did not flip and the flag stayed set, and that the following event performs the flip.

// File: rtl/ltc_pkg.sv
// Package: shared field positions and widths of the local timer cell
// control register. Assumes an 8-bit register with the layout of the brief.
package ltc_pkg;

    localparam int REG_W      = 8;
    localparam int B_MODE     = 0;   // 0 edge, 1 level
    localparam int B_POL      = 1;   // edge: falling enable, level: active low
    localparam int B_SRC      = 2;   // edge: rising enable, level: prescaler enable
    localparam int B_FULL     = 3;   // full-speed clock select
    localparam int B_SEL      = 4;   // select output
    localparam int B_CLR      = 5;   // request clear strobe, write-only
    localparam int B_REQ      = 6;   // coherent-update request

    typedef struct packed {
        logic full;
        logic src;
        logic pol;
        logic mode;
    } cfg_t;

endpackage

// File: rtl/ltc_event_gen.sv
// Event generator: turns the input line into a one-cycle count enable.
// Assumes in_line is already synchronous to clk; it is registered twice
// here so an edge is detected one clock after the line changes.
module ltc_event_gen
    import ltc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_line,
    input  logic presc_stb,
    input  cfg_t cfg,
    output logic cnt_evt
);

    logic [STAGES-1:0] pipe_q;
    logic              cur;
    logic              prev;
    logic              rise;
    logic              fall;
    logic              active;
    logic              edge_evt;
    logic              level_evt;

    // Shift register holding the delayed copies of the input line.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], in_line};
    end

    assign cur  = pipe_q[STAGES-2];
    assign prev = pipe_q[STAGES-1];

    // Edge-mode event: selected transitions, suppressed on full-speed clock.
    always_comb begin
        rise     = cur & ~prev;
        fall     = ~cur & prev;
        edge_evt = ~cfg.full & ((rise & cfg.src) | (fall & cfg.pol));
    end

    // Level-mode event: gate by active level, then by strobe or every clock.
    always_comb begin
        active    = cur ^ cfg.pol;
        level_evt = active & (cfg.src ? presc_stb : 1'b1);
    end

    assign cnt_evt = cfg.mode ? level_evt : edge_evt;

endmodule

// File: rtl/ltc_counter.sv
// Counter: CNT_W-bit up counter that reloads to zero on the reset/overflow
// event, with the reload winning over a simultaneous count.
module ltc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_evt,
    input  logic             reload,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: reload first, then increment on an event.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (reload)  cnt_q <= '0;
        else if (cnt_evt) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/ltc_ctrl_reg.sv
// Control register: configuration bits, select output and the coherent
// update request with its write-only clear strobe (set has priority).
// Assumes one write per cycle; a write of bit5=0 does not touch the request.
module ltc_ctrl_reg
    import ltc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ovf_evt,
    output cfg_t             cfg,
    output logic             sel,
    output logic [REG_W-1:0] rd_data
);

    cfg_t cfg_q;
    logic sel_q;
    logic req_q;
    logic sw_req;
    logic flip;
    logic sel_base;
    logic req_d;

    // Decide whether the request is consumed by this event.
    always_comb begin
        sw_req   = wr_en & wr_data[B_CLR];
        flip     = ovf_evt & req_q & ~sw_req;
        sel_base = wr_en ? wr_data[B_SEL] : sel_q;
        if (sw_req)    req_d = wr_data[B_REQ];
        else if (flip) req_d = 1'b0;
        else           req_d = req_q;
    end

    // Register update for configuration, select and request bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            sel_q <= 1'b0;
            req_q <= 1'b0;
        end else begin
            if (wr_en) cfg_q <= cfg_t'(wr_data[B_FULL:B_MODE]);
            sel_q <= sel_base ^ flip;
            req_q <= req_d;
        end
    end

    assign cfg     = cfg_q;
    assign sel     = sel_q;
    assign rd_data = {1'b0, req_q, 1'b0, sel_q, cfg_q};

endmodule

// File: rtl/ltc_cell.sv
// Local timer cell top: event generator, counter and control register.
// Assumes all inputs are synchronous to clk.
module ltc_cell
    import ltc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_line,
    input  logic             presc_stb,
    input  logic             ovf_evt,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [CNT_W-1:0] cnt,
    output logic             sel_out
);

    cfg_t cfg;
    logic cnt_evt;

    ltc_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ovf_evt (ovf_evt),
        .cfg     (cfg),
        .sel     (sel_out),
        .rd_data (rd_data)
    );

    ltc_event_gen #(.STAGES(2)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_line   (in_line),
        .presc_stb (presc_stb),
        .cfg       (cfg),
        .cnt_evt   (cnt_evt)
    );

    ltc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_evt (cnt_evt),
        .reload  (ovf_evt),
        .cnt     (cnt)
    );

endmodule

// File: rtl/ltc_cell_chk.sv
// Checker: port-level properties of the local timer cell, bound to ltc_cell.
module ltc_cell_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ovf_evt,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic [7:0]       rd_data,
    input logic [CNT_W-1:0] cnt,
    input logic             sel_out
);

    // Clear strobe and bit 7 never read back as 1.
    always @(posedge clk) begin
        if (rst_n) begin
            assert_clr_reads_zero_R8: assert (rd_data[5] == 1'b0 && rd_data[7] == 1'b0);
        end
    end

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> cnt == '0);

    assert_full_speed_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[0] && rd_data[3] && !ovf_evt && !wr_en) |=> $stable(cnt));

    assert_set_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[5] && wr_data[6]) |=> rd_data[6]);

    assert_keep_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[5] && !(ovf_evt && rd_data[6])) |=> rd_data[6] == $past(rd_data[6]));

    assert_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && rd_data[6] && !wr_en) |=> (sel_out != $past(sel_out)) && !rd_data[6]);

    assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(ovf_evt && rd_data[6])) |=> $stable(sel_out));

    assert_sel_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(ovf_evt && rd_data[6])) |=> sel_out == $past(wr_data[4]));

    assert_defer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[5] && wr_data[6] && ovf_evt) |=> rd_data[6] && sel_out == $past(wr_data[4]));

endmodule

bind ltc_cell ltc_cell_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovf_evt (ovf_evt),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .cnt     (cnt),
    .sel_out (sel_out)
);

// File: tb/ltc_cell_tb.sv
// Bench for ltc_cell: table of count-mode vectors, then directed tests.
module ltc_cell_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_line = 1'b0;
    logic        presc_stb = 1'b0;
    logic        ovf_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [15:0] cnt;
    logic        sel_out;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ltc_cell u_dut (
        .clk(clk), .rst_n(rst_n), .in_line(in_line), .presc_stb(presc_stb),
        .ovf_evt(ovf_evt), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cnt(cnt), .sel_out(sel_out)
    );

    // Vector: {ctrl[7:0], pulses[3:0], expected count[3:0]}
    localparam logic [15:0] VEC [8] = '{
        {8'h04, 4'd3, 4'd3},   // R2 rising only
        {8'h02, 4'd3, 4'd3},   // R2 falling only
        {8'h06, 4'd2, 4'd4},   // R2 both directions
        {8'h00, 4'd3, 4'd0},   // R2 no direction
        {8'h0E, 4'd3, 4'd0},   // R3 full speed in edge mode
        {8'h01, 4'd2, 4'd6},   // R4 level high, every clock
        {8'h05, 4'd3, 4'd0},   // R4 level high, prescaler, no strobe
        {8'h06, 4'd1, 4'd2}    // R2 single pulse both edges
    };

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ovf();
        ovf_evt = 1'b1;
        @(negedge clk);
        ovf_evt = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            presc_stb = 1'b1; cyc(1);
            presc_stb = 1'b0; cyc(1);
        end
    endtask

    initial begin
        #760000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc(4);
        check("R1 cnt", int'(cnt), 0);
        check("R1 sel", int'(sel_out), 0);
        check("R1 rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        cyc(1);

        for (int v = 0; v < 8; v++) begin
            wr(VEC[v][15:8]);
            ovf();
            for (int p = 0; p < int'(VEC[v][7:4]); p++) begin
                in_line = 1'b1; cyc(3);
                in_line = 1'b0; cyc(3);
            end
            cyc(4);
            check($sformatf("R2/R3/R4 vector %0d", v), int'(cnt), int'(VEC[v][3:0]));
        end

        // R2 latency and single count on a held level
        wr(8'h04); ovf();
        in_line = 1'b1; cyc(1);
        check("R2 no count after one clock", int'(cnt), 0);
        cyc(1);
        check("R2 count after two clocks", int'(cnt), 1);
        cyc(5);
        check("R2 held level counts once", int'(cnt), 1);
        in_line = 1'b0; cyc(3);

        // R6 config and select read-back
        wr(8'h1B);
        check("R6 sel_out written", int'(sel_out), 1);
        check("R6 read-back", int'(rd_data), 8'h1B);
        wr(8'h00);
        check("R6 sel_out cleared", int'(sel_out), 0);

        // R4 level active low with prescaler
        in_line = 1'b1;
        wr(8'h07); ovf();
        strobes(5);
        check("R4 active low, line high", int'(cnt), 0);
        in_line = 1'b0; cyc(2);
        strobes(4);
        check("R4 active low, line low", int'(cnt), 4);

        // R4 level active high with prescaler
        in_line = 1'b1;
        wr(8'h05); cyc(2); ovf();
        strobes(4);
        check("R4 active high strobes", int'(cnt), 4);
        in_line = 1'b0; cyc(2);
        strobes(3);
        check("R4 inactive holds", int'(cnt), 4);

        // R5 reload wins over simultaneous count
        wr(8'h01); in_line = 1'b1; cyc(5);
        ovf();
        check("R5 reload over count", int'(cnt), 0);
        cyc(1);
        check("R5 count resumes", int'(cnt), 1);

        // R5 wrap modulo 2^16
        ovf();
        cyc(65538);
        check("R5 wrap", int'(cnt), 2);
        in_line = 1'b0;
        wr(8'h00); cyc(2);

        // R7 R8 arm request, clear strobe reads 0
        wr(8'h60);
        check("R7 set with both bits", int'(rd_data[6]), 1);
        check("R8 clear bit reads 0", int'(rd_data[5]), 0);
        wr(8'h40);
        check("R7 bit5=0 leaves flag", int'(rd_data[6]), 1);
        check("R6 write keeps sel 0", int'(sel_out), 0);

        // R9 flip on event, then one-shot
        ovf();
        check("R9 sel flipped", int'(sel_out), 1);
        check("R9 flag cleared", int'(rd_data[6]), 0);
        ovf();
        check("R9 no second flip", int'(sel_out), 1);

        // R7 clear then event does nothing
        wr(8'h70);
        wr(8'h30);
        check("R7 cleared by bit5 only", int'(rd_data[6]), 0);
        ovf();
        check("R7 no flip after clear", int'(sel_out), 1);

        // R10 set write in the same cycle as the event
        wr_en = 1'b1; wr_data = 8'h70; ovf_evt = 1'b1;
        cyc(1);
        wr_en = 1'b0; wr_data = '0; ovf_evt = 1'b0;
        check("R10 no flip", int'(sel_out), 1);
        check("R10 flag stays set", int'(rd_data[6]), 1);
        cyc(2);
        ovf();
        check("R10 deferred flip", int'(sel_out), 0);
        check("R10 flag cleared later", int'(rd_data[6]), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule